// File: doc/BRIEF.md
# PLL Power and Rate Sequencer

This block steps the control pins of an analog PLL macro through power-up, power-down and a change of output rate while the PLL runs. Software or a higher-level controller raises a one-cycle request (bring up, shut down, or retune) together with a new feedback control word and a divide ratio. The sequencer then applies each control change in a fixed order. Where the macro needs settling time, it waits a set number of microsecond ticks from a free-running timebase.

The divide ratio is given as a power of two. The block stores only its exponent, as a 3-bit code. On power-up the supply comes first and isolation is released next, then the loop, the divider outputs and the tuner are enabled. After a settling wait, an optional active-low reset is released. Power-down undoes these steps in the opposite order. A retune switches the tuner off around the register update and marks the update with a one-cycle change strobe. The PLL output settles for the long wait before the block reports idle again.

Top module: `pll_seq`

## Requirements
- R1: After reset: supply off, isolation on, loop enable, divider enables, tuner, reset release and change strobe all low, control word and divider code zero, not busy, not prepared.
- R2: A bring-up request while unprepared raises supply enable on the next cycle. Isolation drops at the first microsecond tick counted after that, and the loop enable rises at the next tick after that (SHORT_US ticks per wait, default 1).
- R3: One cycle after the loop enable rises, all divider enables go high, and one cycle later the tuner goes high.
- R4: Once the tuner is on, the block counts LONG_US ticks (default 20). At the final tick the reset release goes high (only when HAS_RST_REL is 1) and the block turns idle.
- R5: A shutdown request while prepared undoes bring-up one step per cycle. The reset release drops first, then the tuner, then the divider enables, then the loop enable; isolation then rises and supply drops last.
- R6: A retune while prepared clears the tuner on the next cycle. The stored word and code update one cycle later, and the change strobe is high for exactly the following cycle. The tuner returns the cycle after that. Busy stays high until LONG_US further ticks have been counted.
- R7: The stored divider code is the bit index of the lowest set bit of the ratio input (bit 0 = ratio 1). A ratio of zero gives code 0.
- R8: A retune while unprepared updates the word and code on the next cycle and changes nothing else. Busy stays low.
- R9: Requests while busy are ignored. Bring-up while prepared and shutdown while unprepared are also ignored.
- R10: `prepared` equals the loop enable. `busy` is high from the cycle after an accepted sequence request until that sequence completes.
- R11: Requests raised together are resolved by priority. When unprepared, bring-up wins over retune and the registers keep their values. When prepared, shutdown wins over retune.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req_up | input | 1 | Bring-up request |
| req_down | input | 1 | Shutdown request |
| req_retune | input | 1 | Rate change request |
| new_word | input | CW_W | New feedback control word |
| new_ratio | input | RATIO_W | New post-divide ratio, one-hot power of two |
| supply_en | output | 1 | PLL supply enable |
| iso_on | output | 1 | Isolation active |
| loop_en | output | 1 | PLL loop enable |
| div_out_en | output | DIV_EN_W | Extra divider output enables |
| tuner_en | output | 1 | Tuner enable |
| rst_release | output | 1 | Active-low reset release (high = out of reset) |
| ctrl_word | output | CW_W | Stored control word |
| div_code | output | 3 | Stored post-divider exponent |
| word_chg | output | 1 | One-cycle change strobe |
| busy | output | 1 | Sequence in progress |
| prepared | output | 1 | PLL enabled |

## Verification
A wrong sequencer state shows at the control pins on the very next clock. Every step either changes one pin or holds all pins still when it should have moved them. A reference model rebuilt from the step order above is therefore compared with all outputs on every cycle. Timer faults show up later, at the first counted tick where the real exit differs from the expected one. That is one microsecond for the short waits and twenty for the settle waits. A wrong exponent or a lost pending word shows in `div_code` and `ctrl_word` in the cycle the store is due.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_UP_PWR,
      ST_UP_ISO,
      ST_UP_DIV,
      ST_UP_TUNE,
      ST_UP_SETTLE,
      ST_DN_TUNE,
      ST_DN_DIV,
      ST_DN_PLL,
      ST_DN_ISO,
      ST_DN_PWR,
      ST_RT_LOAD,
      ST_RT_STROBE,
      ST_RT_TUNE,
      ST_RT_SETTLE
   } seq_st_t;

   typedef enum logic [1:0] {
      WT_NONE,
      WT_SHORT,
      WT_LONG
   } wait_t;

   localparam int unsigned DIV_CODE_W = 3;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer
   import pll_seq_pkg::*;
#(
   parameter int unsigned SHORT_US = 1,
   parameter int unsigned LONG_US  = 20,
   localparam int unsigned CNT_W   = $clog2(LONG_US + 1)
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  us_tick,
   input  wait_t wait_sel,
   output logic  done
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   always_comb begin
      case (wait_sel)
         WT_SHORT: lim = CNT_W'(SHORT_US);
         WT_LONG:  lim = CNT_W'(LONG_US);
         default:  lim = '0;
      endcase
   end

   assign done = (wait_sel != WT_NONE) && us_tick && (cnt_q == lim - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wait_sel == WT_NONE || done) begin
         cnt_q <= '0;
      end else if (us_tick) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_TICK_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_sel != WT_NONE) |-> (cnt_q < lim)); // R4

endmodule

// File: rtl/pll_seq_ratereg.sv
module pll_seq_ratereg
   import pll_seq_pkg::*;
#(
   parameter int unsigned CW_W    = 22,
   parameter int unsigned RATIO_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_direct,
   input  logic                  load_pending,
   input  logic                  commit,
   input  logic [CW_W-1:0]       new_word,
   input  logic [RATIO_W-1:0]    new_ratio,
   output logic [CW_W-1:0]       ctrl_word,
   output logic [DIV_CODE_W-1:0] div_code
);

   logic [CW_W-1:0]       pend_word_q;
   logic [DIV_CODE_W-1:0] pend_code_q;
   logic [DIV_CODE_W-1:0] enc_code;

   // Exponent of the lowest set bit; zero when no bit is set.
   function automatic logic [DIV_CODE_W-1:0] lowest_set(input logic [RATIO_W-1:0] r);
      logic [DIV_CODE_W-1:0] p;
      p = '0;
      for (int i = RATIO_W - 1; i >= 0; i--) begin
         if (r[i]) p = DIV_CODE_W'(i);
      end
      return p;
   endfunction

   assign enc_code = lowest_set(new_ratio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_word_q <= '0;
         pend_code_q <= '0;
      end else if (load_pending) begin
         pend_word_q <= new_word;
         pend_code_q <= enc_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_word <= '0;
         div_code  <= '0;
      end else if (load_direct) begin
         ctrl_word <= new_word;
         div_code  <= enc_code;
      end else if (commit) begin
         ctrl_word <= pend_word_q;
         div_code  <= pend_code_q;
      end
   end

   AST_SINGLE_LOAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_direct && (commit || load_pending))); // R8

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_direct && !commit) |=> $stable(ctrl_word)); // R6

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
   import pll_seq_pkg::*;
#(
   parameter int unsigned DIV_EN_W    = 2,
   parameter bit          HAS_RST_REL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_up,
   input  logic                req_down,
   input  logic                req_retune,
   input  logic                tmr_done,
   output wait_t               wait_sel,
   output logic                load_direct,
   output logic                load_pending,
   output logic                commit,
   output logic                supply_en,
   output logic                iso_on,
   output logic                loop_en,
   output logic [DIV_EN_W-1:0] div_out_en,
   output logic                tuner_en,
   output logic                rst_release,
   output logic                word_chg,
   output logic                busy
);

   seq_st_t st_q;
   logic    rst_set, rst_clr;
   logic    idle;

   assign idle         = (st_q == ST_IDLE);
   assign busy         = !idle;
   assign load_direct  = idle && !loop_en && !req_up && req_retune;
   assign load_pending = idle && loop_en && !req_down && req_retune;
   assign commit       = (st_q == ST_RT_LOAD);
   assign rst_set      = (st_q == ST_UP_SETTLE) && tmr_done;
   assign rst_clr      = idle && loop_en && req_down;

   always_comb begin
      case (st_q)
         ST_UP_PWR, ST_UP_ISO:        wait_sel = WT_SHORT;
         ST_UP_SETTLE, ST_RT_SETTLE:  wait_sel = WT_LONG;
         default:                     wait_sel = WT_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         supply_en  <= 1'b0;
         iso_on     <= 1'b1;
         loop_en    <= 1'b0;
         div_out_en <= '0;
         tuner_en   <= 1'b0;
         word_chg   <= 1'b0;
      end else begin
         word_chg <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (!loop_en) begin
                  if (req_up) begin
                     supply_en <= 1'b1;
                     st_q      <= ST_UP_PWR;
                  end
               end else if (req_down) begin
                  st_q <= ST_DN_TUNE;
               end else if (req_retune) begin
                  tuner_en <= 1'b0;
                  st_q     <= ST_RT_LOAD;
               end
            end
            ST_UP_PWR: if (tmr_done) begin
               iso_on <= 1'b0;
               st_q   <= ST_UP_ISO;
            end
            ST_UP_ISO: if (tmr_done) begin
               loop_en <= 1'b1;
               st_q    <= ST_UP_DIV;
            end
            ST_UP_DIV: begin
               div_out_en <= '1;
               st_q       <= ST_UP_TUNE;
            end
            ST_UP_TUNE: begin
               tuner_en <= 1'b1;
               st_q     <= ST_UP_SETTLE;
            end
            ST_UP_SETTLE: if (tmr_done) st_q <= ST_IDLE;
            ST_DN_TUNE: begin
               tuner_en <= 1'b0;
               st_q     <= ST_DN_DIV;
            end
            ST_DN_DIV: begin
               div_out_en <= '0;
               st_q       <= ST_DN_PLL;
            end
            ST_DN_PLL: begin
               loop_en <= 1'b0;
               st_q    <= ST_DN_ISO;
            end
            ST_DN_ISO: begin
               iso_on <= 1'b1;
               st_q   <= ST_DN_PWR;
            end
            ST_DN_PWR: begin
               supply_en <= 1'b0;
               st_q      <= ST_IDLE;
            end
            ST_RT_LOAD:   st_q <= ST_RT_STROBE;
            ST_RT_STROBE: begin
               word_chg <= 1'b1;
               st_q     <= ST_RT_TUNE;
            end
            ST_RT_TUNE: begin
               tuner_en <= 1'b1;
               st_q     <= ST_RT_SETTLE;
            end
            ST_RT_SETTLE: if (tmr_done) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   generate
      if (HAS_RST_REL) begin : g_rst_rel
         logic rel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       rel_q <= 1'b0;
            else if (rst_clr) rel_q <= 1'b0;
            else if (rst_set) rel_q <= 1'b1;
         end
         assign rst_release = rel_q;
      end else begin : g_no_rst_rel
         assign rst_release = 1'b0;
      end
   endgenerate

   AST_ISO_WHEN_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_en |-> iso_on); // R5

   AST_LOOP_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> (supply_en && !iso_on)); // R2

   AST_TUNER_NEEDS_DIVIDERS: assert property (@(posedge clk) disable iff (!rst_n)
      tuner_en |-> (loop_en && (&div_out_en))); // R3

   AST_RELEASE_NEEDS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_release |-> loop_en); // R4

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_chg |=> !word_chg); // R6

   AST_STROBE_TUNER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      word_chg |-> !tuner_en); // R6

   AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_up && !loop_en && $past(loop_en)) |=> !supply_en || busy); // R9

endmodule

// File: rtl/pll_seq.sv
module pll_seq
   import pll_seq_pkg::*;
#(
   parameter int unsigned CW_W        = 22,
   parameter int unsigned RATIO_W     = 8,
   parameter int unsigned DIV_EN_W    = 2,
   parameter bit          HAS_RST_REL = 1'b1,
   parameter int unsigned SHORT_US    = 1,
   parameter int unsigned LONG_US     = 20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  us_tick,
   input  logic                  req_up,
   input  logic                  req_down,
   input  logic                  req_retune,
   input  logic [CW_W-1:0]       new_word,
   input  logic [RATIO_W-1:0]    new_ratio,
   output logic                  supply_en,
   output logic                  iso_on,
   output logic                  loop_en,
   output logic [DIV_EN_W-1:0]   div_out_en,
   output logic                  tuner_en,
   output logic                  rst_release,
   output logic [CW_W-1:0]       ctrl_word,
   output logic [DIV_CODE_W-1:0] div_code,
   output logic                  word_chg,
   output logic                  busy,
   output logic                  prepared
);

   generate
      if (CW_W < 1 || CW_W > 32) begin : g_bad_cw
         $error("CW_W must lie in 1..32");
      end
      if (RATIO_W < 2 || RATIO_W > 8) begin : g_bad_ratio
         $error("RATIO_W must lie in 2..8 for a 3-bit exponent");
      end
      if (DIV_EN_W < 1) begin : g_bad_div
         $error("DIV_EN_W must be at least 1");
      end
      if (SHORT_US < 1 || LONG_US < SHORT_US) begin : g_bad_wait
         $error("waits need 1 <= SHORT_US <= LONG_US");
      end
   endgenerate

   wait_t wait_sel;
   logic  tmr_done;
   logic  load_direct, load_pending, commit;

   pll_seq_timer #(
      .SHORT_US (SHORT_US),
      .LONG_US  (LONG_US)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .us_tick  (us_tick),
      .wait_sel (wait_sel),
      .done     (tmr_done)
   );

   pll_seq_fsm #(
      .DIV_EN_W    (DIV_EN_W),
      .HAS_RST_REL (HAS_RST_REL)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_up       (req_up),
      .req_down     (req_down),
      .req_retune   (req_retune),
      .tmr_done     (tmr_done),
      .wait_sel     (wait_sel),
      .load_direct  (load_direct),
      .load_pending (load_pending),
      .commit       (commit),
      .supply_en    (supply_en),
      .iso_on       (iso_on),
      .loop_en      (loop_en),
      .div_out_en   (div_out_en),
      .tuner_en     (tuner_en),
      .rst_release  (rst_release),
      .word_chg     (word_chg),
      .busy         (busy)
   );

   pll_seq_ratereg #(
      .CW_W    (CW_W),
      .RATIO_W (RATIO_W)
   ) u_ratereg (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_direct  (load_direct),
      .load_pending (load_pending),
      .commit       (commit),
      .new_word     (new_word),
      .new_ratio    (new_ratio),
      .ctrl_word    (ctrl_word),
      .div_code     (div_code)
   );

   assign prepared = loop_en;

   AST_PREPARED_TRACKS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prepared) |-> busy); // R10

endmodule

// File: tb/pll_seq_bench.sv
module pll_seq_bench;

   localparam int CW_W     = 22;
   localparam int RATIO_W  = 8;
   localparam int DIV_EN_W = 2;
   localparam int LONG_US  = 20;
   localparam int SHORT_US = 1;

   // model actions
   localparam int A_NOP = 0, A_ISO_OFF = 1, A_PLL_ON = 2, A_DIV_ON = 3, A_TUNE_ON = 4,
                  A_RST_ON = 5, A_TUNE_OFF = 6, A_DIV_OFF = 7, A_PLL_OFF = 8,
                  A_ISO_ON = 9, A_PWR_OFF = 10, A_WRITE = 11, A_CHG = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic us_tick = 1'b0;
   logic req_up = 1'b0, req_down = 1'b0, req_retune = 1'b0;
   logic [CW_W-1:0]    new_word = '0;
   logic [RATIO_W-1:0] new_ratio = '0;
   logic supply_en, iso_on, loop_en, tuner_en, rst_release, word_chg, busy, prepared;
   logic [DIV_EN_W-1:0] div_out_en;
   logic [CW_W-1:0]     ctrl_word;
   logic [2:0]          div_code;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   int tick_phase = 0;
   int chg_seen = 0;

   always #5 clk = ~clk;

   pll_seq u_pll_seq (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
      .req_up(req_up), .req_down(req_down), .req_retune(req_retune),
      .new_word(new_word), .new_ratio(new_ratio),
      .supply_en(supply_en), .iso_on(iso_on), .loop_en(loop_en),
      .div_out_en(div_out_en), .tuner_en(tuner_en), .rst_release(rst_release),
      .ctrl_word(ctrl_word), .div_code(div_code), .word_chg(word_chg),
      .busy(busy), .prepared(prepared)
   );

   // reference model state
   bit m_pwr, m_iso, m_pll, m_div, m_tune, m_rst, m_chg;
   logic [CW_W-1:0] m_cw, p_cw;
   logic [2:0]      m_pd, p_pd;
   int q[$];
   int tcnt;

   function automatic logic [2:0] exp_code(input logic [RATIO_W-1:0] r);
      for (int k = 0; k < RATIO_W; k++) if (r[k]) return 3'(k);
      return 3'd0;
   endfunction

   function automatic void exec(input int a);
      case (a)
         A_ISO_OFF:  m_iso = 0;
         A_PLL_ON:   m_pll = 1;
         A_DIV_ON:   m_div = 1;
         A_TUNE_ON:  m_tune = 1;
         A_RST_ON:   m_rst = 1;
         A_TUNE_OFF: m_tune = 0;
         A_DIV_OFF:  m_div = 0;
         A_PLL_OFF:  m_pll = 0;
         A_ISO_ON:   m_iso = 1;
         A_PWR_OFF:  m_pwr = 0;
         A_WRITE:    begin m_cw = p_cw; m_pd = p_pd; end
         A_CHG:      m_chg = 1;
         default:    ;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pwr = 0; m_iso = 1; m_pll = 0; m_div = 0; m_tune = 0; m_rst = 0; m_chg = 0;
         m_cw = '0; m_pd = '0; p_cw = '0; p_pd = '0; q.delete(); tcnt = 0;
      end else begin
         m_chg = 0;
         if (q.size() == 0) begin
            if (!m_pll) begin
               if (req_up) begin
                  m_pwr = 1;
                  q = '{SHORT_US*16 + A_ISO_OFF, SHORT_US*16 + A_PLL_ON, A_DIV_ON,
                        A_TUNE_ON, LONG_US*16 + A_RST_ON};
               end else if (req_retune) begin
                  m_cw = new_word; m_pd = exp_code(new_ratio);
               end
            end else if (req_down) begin
               m_rst = 0;
               q = '{A_TUNE_OFF, A_DIV_OFF, A_PLL_OFF, A_ISO_ON, A_PWR_OFF};
            end else if (req_retune) begin
               m_tune = 0; p_cw = new_word; p_pd = exp_code(new_ratio);
               q = '{A_WRITE, A_CHG, A_TUNE_ON, LONG_US*16 + A_NOP};
            end
         end else begin
            if (q[0] / 16 == 0) begin
               exec(q[0] % 16); void'(q.pop_front());
            end else if (us_tick) begin
               tcnt++;
               if (tcnt == q[0] / 16) begin
                  exec(q[0] % 16); void'(q.pop_front()); tcnt = 0;
               end
            end
         end
      end
   end

   task automatic check(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // every-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      cycles++;
      tick_phase = (tick_phase + 1) % 4;
      us_tick = (tick_phase == 0);
      if (rst_n) begin
         if (word_chg) chg_seen++;
         check("R2 supply_en", supply_en, m_pwr);
         check("R2 iso_on", iso_on, m_iso);
         check("R3 loop_en", loop_en, m_pll);
         check("R3 div_out_en", div_out_en, {DIV_EN_W{m_div}});
         check("R3 tuner_en", tuner_en, m_tune);
         check("R4 rst_release", rst_release, m_rst);
         check("R6 ctrl_word", ctrl_word, m_cw);
         check("R6 div_code", div_code, m_pd);
         check("R6 word_chg", word_chg, m_chg);
         check("R10 busy", busy, q.size() != 0);
         check("R10 prepared", prepared, m_pll);
      end
      if (cycles > 100000) begin
         bad++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic pulse(input bit up, input bit dn, input bit rt,
                        input logic [CW_W-1:0] w, input logic [RATIO_W-1:0] r);
      @(negedge clk);
      req_up = up; req_down = dn; req_retune = rt; new_word = w; new_ratio = r;
      @(negedge clk);
      req_up = 0; req_down = 0; req_retune = 0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
   endtask

   function automatic logic [5:0] pins();
      return {rst_release, tuner_en, |div_out_en, loop_en, iso_on, supply_en};
   endfunction

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 supply_en", supply_en, 0);
      check("R1 iso_on", iso_on, 1);
      check("R1 enables", {loop_en, div_out_en, tuner_en, rst_release, word_chg}, 0);
      check("R1 regs", {ctrl_word, div_code}, 0);
      check("R1 busy/prepared", {busy, prepared}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // R8 retune while unprepared: registers only
      pulse(0, 0, 1, 22'h12345, 8'h10);
      check("R8 ctrl_word", ctrl_word, 22'h12345);
      check("R7 div_code ratio 16", div_code, 4);
      check("R8 busy", busy, 0);
      check("R8 supply", supply_en, 0);

      // R9 shutdown while unprepared is ignored
      pulse(0, 1, 0, '0, '0);
      check("R9 down when unprepared", {busy, supply_en, iso_on}, 3'b001);

      // bring-up with ignored requests mid-sequence
      pulse(1, 0, 0, '0, '0);
      check("R10 busy after up", busy, 1);
      check("R2 supply first", pins(), 6'b000011);
      pulse(1, 1, 1, 22'h3FFFF, 8'h01);
      check("R9 busy requests ignored", ctrl_word, 22'h12345);
      wait_idle();
      check("R4 release after settle", rst_release, 1);
      check("R10 prepared", prepared, 1);

      // R9 bring-up while prepared ignored
      pulse(1, 0, 0, '0, '0);
      check("R9 up when prepared", busy, 0);

      // R6 retune while prepared
      chg_seen = 0;
      pulse(0, 0, 1, 22'h3ABCD, 8'h0C);
      check("R6 tuner off first", {tuner_en, ctrl_word}, {1'b0, 22'h12345});
      @(negedge clk);
      check("R6 word stored", ctrl_word, 22'h3ABCD);
      check("R7 div_code lowest bit", div_code, 2);
      wait_idle();
      check("R6 one strobe", chg_seen, 1);
      check("R6 tuner back", tuner_en, 1);

      // R7 zero ratio
      pulse(0, 0, 1, 22'h00001, 8'h00);
      wait_idle();
      check("R7 zero ratio", div_code, 0);

      // R11 + R5: shutdown wins over retune; reverse order
      pulse(0, 1, 1, 22'h2AAAA, 8'h80);
      check("R5 step0", pins(), 6'b011101);
      @(negedge clk); check("R5 step1", pins(), 6'b001101);
      @(negedge clk); check("R5 step2", pins(), 6'b000101);
      @(negedge clk); check("R5 step3", pins(), 6'b000001);
      @(negedge clk); check("R5 step4", pins(), 6'b000011);
      @(negedge clk); check("R5 step5", pins(), 6'b000010);
      wait_idle();
      check("R11 down over retune", ctrl_word, 22'h00001);

      // R11 bring-up wins over retune when unprepared
      pulse(1, 0, 1, 22'h15555, 8'h04);
      check("R11 up over retune", {busy, ctrl_word}, {1'b1, 22'h00001});
      wait_idle();
      check("R11 prepared after up", prepared, 1);

      repeat (5) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule